// File: doc/BRIEF.md
# Multi-Level Cell Sense Controller

This block turns the analog level held by a multi-level memory cell into an N-bit value. The cell holds one of 2^N levels (with N=2 the four levels read back as 00, 01, 10 and 11). The analog references and comparators sit outside the block. The controller supplies the reference index and the precharge and request strobes, and it reads back the comparator decisions.

Two read styles are chosen per conversion. In the sequential style a binary search runs over the reference indices: each comparison is made against the middle of the level range that is still open, so a result takes N comparisons. The controller waits for a valid strobe from the comparator before it picks the next reference. The comparison sense stage must be precharged before use. With the dual-stage option enabled, the two stages take turns: one compares while the other precharges, which hides most of the precharge time. In the parallel style all 2^N-1 comparator outputs arrive together as a thermometer word and are encoded in one cycle. A broken thermometer word is flagged as an error.

Top module: `mlc_sense_ctrl`

## Requirements
- R1: After reset done_o, busy_o, cmp_req_o and both pchg_o bits are 0.
- R2: In sequential mode the open range starts at 0..2^N-1. Each comparison drives ref_idx_o to the ceiling of (low+high)/2. A response with cmp_hi_i=1 means level >= ref_idx_o and raises low to that index; otherwise high becomes index-1. The final low value is returned on data_o.
- R3: A sequential conversion issues exactly N comparator requests. ref_idx_o holds steady while cmp_req_o is high and cmp_valid_i is low. cmp_req_o is 0 once the result is out.
- R4: With dual_i=0 every comparison uses stage 0 (stage_o=0) after PCHG_CYC cycles with pchg_o[0]=1. When the comparator answers D cycles after a request, the start-to-done latency is N*(PCHG_CYC+D+1) cycles and no precharge is active during a wait.
- R5: With dual_i=1 stage_o alternates 0,1,0,... Only the first comparison waits for a full precharge. While a non-final comparison waits, the other stage is precharged (pchg_o bit of the other stage set). Latency is PCHG_CYC+D+1+(N-1)*max(PCHG_CYC,D+1).
- R6: In parallel mode therm_i bit k means level > k. data_o is one plus the index of the highest set bit, or 0 when none is set, and done_o rises one cycle after the start edge.
- R7: err_o is 1 in parallel mode exactly when therm_i is not of the form 2^r-1. err_o is 0 for sequential results.
- R8: done_o is high for one cycle per conversion with busy_o low. busy_o is high from the start edge until the result.
- R9: start_i while busy_o is high is ignored: no extra done_o and the running result is unchanged.
- R10: At most one pchg_o bit is set, and never the bit of the stage being compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a conversion when idle |
| par_mode_i | input | 1 | 1 = parallel thermometer read, 0 = binary search |
| dual_i | input | 1 | 1 = alternate two sense stages in sequential mode |
| cmp_req_o | output | 1 | Comparison requested at ref_idx_o |
| ref_idx_o | output | N | Reference level index for the comparison |
| stage_o | output | 1 | Sense stage used by the current comparison |
| pchg_o | output | 2 | Precharge strobe per sense stage |
| cmp_valid_i | input | 1 | Comparator decision valid |
| cmp_hi_i | input | 1 | Decision: cell level >= reference index |
| therm_i | input | 2^N-1 | Parallel comparator outputs |
| busy_o | output | 1 | Sequential conversion in progress |
| done_o | output | 1 | Result valid, one cycle |
| data_o | output | N | Read result |
| err_o | output | 1 | Non-monotonic thermometer word |

## Verification
The bench builds the block with N=3 and PCHG_CYC=2. Eight levels give a three-step search whose stage order 0,1,0 shows both alternation and a final step with no lookahead precharge. The 7-bit thermometer input is small enough to sweep all 128 words, so every non-monotonic pattern is seen. Comparator delays of 0, 1 and 3 cycles put the wait both shorter than and longer than the precharge. This exercises both branches of the dual-stage latency.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_PCHG,
    SEQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/mlc_therm_enc.sv
module mlc_therm_enc #(
  parameter int N = 3,
  localparam int L = 1 << N
) (
  input  logic [L-2:0] therm_i,
  output logic [N-1:0] code_o,
  output logic         bad_o
);
  logic [L-2:0] mask;

  always_comb begin
    code_o = '0;
    for (int k = 0; k < L - 1; k++) begin
      if (therm_i[k]) code_o = N'(k + 1);
    end
    for (int k = 0; k < L - 1; k++) begin
      mask[k] = (k < int'(code_o));
    end
    bad_o = (therm_i != mask);
  end

  // R7
  always_comb begin
    if (!bad_o) enc_count_chk: assert (int'(code_o) == $countones(therm_i));
  end
endmodule

// File: rtl/mlc_bsearch.sv
module mlc_bsearch #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         step_i,
  input  logic         hi_i,
  output logic [N-1:0] mid_o,
  output logic [N-1:0] lo_o
);
  logic [N-1:0] lo_q, hi_q;
  logic [N:0]   sum;

  assign sum   = {1'b0, lo_q} + {1'b0, hi_q} + (N+1)'(1);
  assign mid_o = sum[N:1];
  assign lo_o  = lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '1;
    end else if (init_i) begin
      lo_q <= '0;
      hi_q <= '1;
    end else if (step_i) begin
      if (hi_i) lo_q <= mid_o;
      else      hi_q <= mid_o - N'(1);
    end
  end

  // R2
  lo_hi_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_q <= hi_q);
endmodule

// File: rtl/mlc_seq_ctrl.sv
module mlc_seq_ctrl
  import mlc_pkg::*;
#(
  parameter int N        = 3,
  parameter int PCHG_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       dual_i,
  input  logic       cmp_valid_i,
  output logic       cmp_req_o,
  output logic       stage_o,
  output logic [1:0] pchg_o,
  output logic       step_o,
  output logic       fin_o,
  output logic       busy_o
);
  localparam int SW = $clog2(N) + 1;
  localparam int PW = $clog2(PCHG_CYC + 1) + 1;

  seq_state_e    state_q;
  logic [SW-1:0] step_q;
  logic [PW-1:0] pre_q, pre_nxt;
  logic          stage_q, dual_q, last;

  assign last      = (step_q == SW'(N - 1));
  assign pre_nxt   = (pre_q < PW'(PCHG_CYC)) ? pre_q + PW'(1) : pre_q;
  assign cmp_req_o = (state_q == SEQ_WAIT);
  assign stage_o   = stage_q;
  assign step_o    = cmp_req_o && cmp_valid_i;
  assign fin_o     = step_o && last;
  assign busy_o    = (state_q != SEQ_IDLE);

  always_comb begin
    pchg_o = 2'b00;
    if (state_q == SEQ_PCHG) pchg_o[stage_q] = 1'b1;
    else if (state_q == SEQ_WAIT && dual_q && !last && pre_q < PW'(PCHG_CYC))
      pchg_o[~stage_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
      pre_q   <= '0;
      stage_q <= 1'b0;
      dual_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (go_i) begin
          state_q <= SEQ_PCHG;
          step_q  <= '0;
          pre_q   <= '0;
          stage_q <= 1'b0;
          dual_q  <= dual_i;
        end
        SEQ_PCHG: begin
          if (pre_q + PW'(1) == PW'(PCHG_CYC)) begin
            state_q <= SEQ_WAIT;
            pre_q   <= '0;
          end else begin
            pre_q <= pre_q + PW'(1);
          end
        end
        SEQ_WAIT: begin
          if (cmp_valid_i) begin
            if (last) begin
              state_q <= SEQ_IDLE;
            end else begin
              step_q <= step_q + SW'(1);
              if (dual_q) begin
                stage_q <= ~stage_q;
                if (pre_nxt == PW'(PCHG_CYC)) begin
                  pre_q <= '0;
                end else begin
                  state_q <= SEQ_PCHG;
                  pre_q   <= pre_nxt;
                end
              end else begin
                state_q <= SEQ_PCHG;
                pre_q   <= '0;
              end
            end
          end else if (dual_q && !last) begin
            pre_q <= pre_nxt;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R10
  pchg_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pchg_o));

  // R10
  pchg_busy_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_o |-> !pchg_o[stage_o]);

  // R3
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> step_q < SW'(N));
endmodule

// File: rtl/mlc_sense_ctrl.sv
module mlc_sense_ctrl #(
  parameter int N        = 3,
  parameter int PCHG_CYC = 2,
  localparam int L       = 1 << N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         par_mode_i,
  input  logic         dual_i,
  output logic         cmp_req_o,
  output logic [N-1:0] ref_idx_o,
  output logic         stage_o,
  output logic [1:0]   pchg_o,
  input  logic         cmp_valid_i,
  input  logic         cmp_hi_i,
  input  logic [L-2:0] therm_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] data_o,
  output logic         err_o
);
  logic         go, go_par, go_seq, step, fin;
  logic [N-1:0] lo_val, enc_code, fin_val;
  logic         enc_bad;

  assign go     = start_i && !busy_o;
  assign go_par = go && par_mode_i;
  assign go_seq = go && !par_mode_i;

  mlc_seq_ctrl #(.N(N), .PCHG_CYC(PCHG_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_seq),
    .dual_i     (dual_i),
    .cmp_valid_i(cmp_valid_i),
    .cmp_req_o  (cmp_req_o),
    .stage_o    (stage_o),
    .pchg_o     (pchg_o),
    .step_o     (step),
    .fin_o      (fin),
    .busy_o     (busy_o)
  );

  mlc_bsearch #(.N(N)) u_search (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(go_seq),
    .step_i(step),
    .hi_i  (cmp_hi_i),
    .mid_o (ref_idx_o),
    .lo_o  (lo_val)
  );

  mlc_therm_enc #(.N(N)) u_enc (
    .therm_i(therm_i),
    .code_o (enc_code),
    .bad_o  (enc_bad)
  );

  assign fin_val = cmp_hi_i ? ref_idx_o : lo_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      data_o <= '0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_par) begin
        done_o <= 1'b1;
        data_o <= enc_code;
        err_o  <= enc_bad;
      end else if (fin) begin
        done_o <= 1'b1;
        data_o <= fin_val;
        err_o  <= 1'b0;
      end
    end
  end

  // R3
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_o && !cmp_valid_i |=> $stable(ref_idx_o));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R6
  par_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && par_mode_i && !busy_o |=> done_o && !busy_o);

  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !fin |=> !done_o);
endmodule

// File: tb/mlc_sense_ctrl_bench.sv
module mlc_sense_ctrl_bench;
  localparam int N = 3;
  localparam int L = 1 << N;
  localparam int P = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, par = 1'b0, dual = 1'b0;
  logic         cmp_valid = 1'b0, cmp_hi = 1'b0;
  logic [L-2:0] therm = '0;
  logic         cmp_req_o, stage_o, busy_o, done_o, err_o;
  logic [N-1:0] ref_idx_o, data_o;
  logic [1:0]   pchg_o;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mlc_sense_ctrl #(.N(N), .PCHG_CYC(P)) u_mlc_sense_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .par_mode_i(par),
    .dual_i(dual), .cmp_req_o(cmp_req_o), .ref_idx_o(ref_idx_o),
    .stage_o(stage_o), .pchg_o(pchg_o), .cmp_valid_i(cmp_valid),
    .cmp_hi_i(cmp_hi), .therm_i(therm), .busy_o(busy_o), .done_o(done_o),
    .data_o(data_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic seq_run(input int lvl, input bit dl, input int d);
    int lo = 0, hi = L - 1, mid, cs, g, lat, cost;
    @(negedge clk);
    start = 1'b1; par = 1'b0; dual = dl; cs = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o == 1'b1, "R8 busy", int'(busy_o), 1);
    for (int s = 0; s < N; s++) begin
      g = 0;
      while (!cmp_req_o && g < 50) begin @(negedge clk); g++; end
      mid = (lo + hi + 1) / 2;
      chk(cmp_req_o == 1'b1, "R3 request", int'(cmp_req_o), 1);
      chk(int'(ref_idx_o) == mid, "R2 ref_idx", int'(ref_idx_o), mid);
      chk(int'(stage_o) == (dl ? s % 2 : 0), dl ? "R5 stage" : "R4 stage",
          int'(stage_o), dl ? s % 2 : 0);
      if (s == 0) chk(pchg_o == (dl ? 2'b10 : 2'b00), dl ? "R5 pchg" : "R4 pchg",
                      int'(pchg_o), dl ? 2 : 0);
      repeat (d) @(negedge clk);
      cmp_valid = 1'b1;
      cmp_hi = (lvl >= mid);
      if (s == 1) begin start = 1'b1; par = 1'b1; therm = '1; end
      @(negedge clk);
      cmp_valid = 1'b0; start = 1'b0; par = 1'b0; therm = '0;
      if (s == 1) chk(done_o == 1'b0, "R9 no done", int'(done_o), 0);
      if (lvl >= mid) lo = mid; else hi = mid - 1;
    end
    lat = cyc - cs;
    cost = (P > d + 1) ? P : d + 1;
    chk(done_o == 1'b1, "R8 done", int'(done_o), 1);
    chk(busy_o == 1'b0, "R8 idle at done", int'(busy_o), 0);
    chk(int'(data_o) == lvl, "R2 result", int'(data_o), lvl);
    chk(err_o == 1'b0, "R7 seq err", int'(err_o), 0);
    if (dl) chk(lat == P + d + 1 + (N - 1) * cost, "R5 latency", lat, P + d + 1 + (N - 1) * cost);
    else    chk(lat == N * (P + d + 1), "R4 latency", lat, N * (P + d + 1));
    @(negedge clk);
    chk(done_o == 1'b0, "R8 one cycle", int'(done_o), 0);
    chk(cmp_req_o == 1'b0, "R3 no extra request", int'(cmp_req_o), 0);
  endtask

  task automatic par_run(input int t);
    int top, cnt, em;
    top = 0; cnt = 0;
    for (int k = 0; k < L - 1; k++) begin
      if (t[k]) begin top = k + 1; cnt++; end
    end
    em = (1 << cnt) - 1;
    @(negedge clk);
    start = 1'b1; par = 1'b1; therm = (L-1)'(t);
    @(negedge clk);
    start = 1'b0; par = 1'b0; therm = '0;
    chk(done_o == 1'b1, "R6 done", int'(done_o), 1);
    chk(int'(data_o) == top, "R6 code", int'(data_o), top);
    chk(int'(err_o) == int'(t != em), "R7 err", int'(err_o), int'(t != em));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    chk(cmp_req_o == 1'b0, "R1 req", int'(cmp_req_o), 0);
    chk(pchg_o == 2'b00, "R1 pchg", int'(pchg_o), 0);
    rst_n = 1'b1;
    for (int dl = 0; dl < 2; dl++) begin
      for (int di = 0; di < 3; di++) begin
        for (int lvl = 0; lvl < L; lvl++) begin
          seq_run(lvl, bit'(dl), (di == 2) ? 3 : di);
        end
      end
    end
    for (int t = 0; t < (1 << (L - 1)); t++) par_run(t);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule